// File: doc/BRIEF.md
# External Register Bus Interface

This block links a small processor core to as many as eight user-defined registers outside the core. The registers share one 16-bit bidirectional data bus. The block drives a latched 3-bit register select, a direction line, an active-low access strobe and an output enable for the pad drivers. It also takes a ready line from the external side, which lets a slow device lengthen the access.

The core raises a single-cycle request with a direction, an address and write data. The block returns a one-clock `done` pulse. For reads, `rd_data` is updated on the same edge.

A configuration input can add one internal wait state to every external access. When the on-chip codec port or the timer is switched on, the upper half of the register space (addresses 4 to 7) belongs to those peripherals. Requests to those addresses finish without any activity on the external bus.

Top module: `xreg_bus_if`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the block is in input mode. In that state `bus_oe`=0, `dir_n`=1, `strobe_n`=1 and `done`=0.
- R2: `bus_oe` is 1 and `dir_n` is 0 only while an external write access is in progress. At every other time `bus_oe`=0 and `dir_n`=1, which covers reads, idle cycles and the cycle after completion.
- R3: `ext_addr` carries the requested register address for the whole of an external access, and all eight addresses 0..7 can be reached. During a write, `bus_out` holds the write data unchanged until the strobe rises.
- R4: The clock edge that accepts a request drives `strobe_n` low. With `ready`=1 and no wait state, the next edge raises `strobe_n` and produces `done`, so `done` goes high two edges after the request is presented. An external device stores write data on the rising edge of `strobe_n`.
- R5: `done` is a one-cycle pulse. On a read, `rd_data` takes the value of `bus_in` at the completing clock edge and holds it until the next external read completes.
- R6: Each rising clock edge during an access at which `ready`=0 delays completion by one cycle. Throughout that time the strobe, direction, address and data outputs stay unchanged.
- R7: With `wait_en`=1, the first edge after acceptance never completes the access. The access ends at the first later edge with `ready`=1. A stall on `ready` that covers that first edge therefore overlaps the wait state and does not add to it.
- R8: If `codec_en` or `timer_en` is 1, a request to an address of 4 or more produces `done` one edge after the request. In that case `strobe_n` does not fall and `rd_data` does not change. Addresses 0..3 still reach the external bus.
- R9: A request presented while an external access is in progress is ignored. It causes no change of address and no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Single-cycle access request from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address of the request |
| req_wdata | input | 16 | Write data of the request |
| rd_data | output | 16 | Data captured by the last external read |
| done | output | 1 | One-cycle completion pulse |
| wait_en | input | 1 | Adds one internal wait state per external access |
| codec_en | input | 1 | Codec port on: addresses 4..7 are internal |
| timer_en | input | 1 | Timer on: addresses 4..7 are internal |
| bus_in | input | 16 | Data bus as seen at the pads |
| bus_out | output | 16 | Data the block drives toward the pads |
| bus_oe | output | 1 | Pad output enable for the data bus |
| dir_n | output | 1 | Bus direction: 0 = block drives, 1 = input mode |
| ext_addr | output | 3 | Latched external register select |
| strobe_n | output | 1 | Active-low access strobe |
| ready | input | 1 | External ready; 0 stretches the access |

## Verification
The bench writes a distinct pattern to each of the eight addresses and reads every one back. This shows whether the latched address is wrong or the read capture takes the wrong bus sample. Latency is measured under five conditions: ready held high, ready stalled for several cycles, the wait state alone, the wait state combined with a one-cycle stall, and the wait state combined with a longer stall. Together these distinguish additive from overlapping stretching. Reserved-address requests are sent with the codec bit set, with the timer bit set, and to a low address while a peripheral is on. This separates the claim decode from the enable logic. A request injected during a stalled access shows whether the block re-arms while it is busy.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
   typedef enum logic [0:0] {
      XS_IDLE = 1'b0,
      XS_XFER = 1'b1
   } xs_state_t;
endpackage

// File: rtl/xreg_claim.sv
module xreg_claim #(
   parameter int ADDR_W    = 3,
   parameter int RSVD_BASE = 4,
   parameter bit RSVD_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              periph_on,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] BASE_V = RSVD_BASE[ADDR_W-1:0];

   if (RSVD_BASE < 0 || RSVD_BASE >= (1 << ADDR_W)) begin : g_bad_base
      $error("xreg_claim: RSVD_BASE outside the address space");
   end

   generate
      if (RSVD_EN) begin : g_claim
         assign hit = periph_on && (addr >= BASE_V);
      end else begin : g_noclaim
         logic unused_in;
         assign unused_in = ^{addr, periph_on};
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xreg_wait.sv
module xreg_wait #(
   parameter int WAIT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic wait_en,
   output logic pend
);
   localparam int CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(WAIT_CYCLES);

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("xreg_wait: WAIT_CYCLES must be at least one");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= wait_en ? LOAD_V : '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pend = (cnt_q != '0);

   // R7
   wait_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xreg_bus_if.sv
module xreg_bus_if #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int RSVD_BASE   = 4,
   parameter bit RSVD_EN     = 1'b1,
   parameter int WAIT_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   input  logic              wait_en,
   input  logic              codec_en,
   input  logic              timer_en,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              dir_n,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              strobe_n,
   input  logic              ready
);
   import xreg_pkg::*;

   if (DATA_W < 1) begin : g_bad_data
      $error("xreg_bus_if: DATA_W must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("xreg_bus_if: ADDR_W must be positive");
   end

   xs_state_t         st_q;
   logic              claim_hit;
   logic              wait_pend;
   logic              start_ext;
   logic              finish;
   logic              wr_q;
   logic              oe_q;
   logic              dir_n_q;
   logic              stb_n_q;
   logic              done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;

   xreg_claim #(
      .ADDR_W    (ADDR_W),
      .RSVD_BASE (RSVD_BASE),
      .RSVD_EN   (RSVD_EN)
   ) u_claim (
      .addr      (req_addr),
      .periph_on (codec_en | timer_en),
      .hit       (claim_hit)
   );

   assign start_ext = (st_q == XS_IDLE) && req_valid && !claim_hit;
   assign finish    = (st_q == XS_XFER) && !wait_pend && ready;

   xreg_wait #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_ext),
      .wait_en (wait_en),
      .pend    (wait_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= XS_IDLE;
         wr_q    <= 1'b0;
         oe_q    <= 1'b0;
         dir_n_q <= 1'b1;
         stb_n_q <= 1'b1;
         done_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            XS_IDLE: begin
               if (req_valid && claim_hit) begin
                  done_q <= 1'b1;
               end else if (start_ext) begin
                  st_q    <= XS_XFER;
                  wr_q    <= req_write;
                  oe_q    <= req_write;
                  dir_n_q <= ~req_write;
                  stb_n_q <= 1'b0;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
               end
            end
            XS_XFER: begin
               if (finish) begin
                  st_q    <= XS_IDLE;
                  oe_q    <= 1'b0;
                  dir_n_q <= 1'b1;
                  stb_n_q <= 1'b1;
                  done_q  <= 1'b1;
                  if (!wr_q) begin
                     rd_q <= bus_in;
                  end
               end
            end
            default: st_q <= XS_IDLE;
         endcase
      end
   end

   assign rd_data  = rd_q;
   assign done     = done_q;
   assign bus_out  = wdata_q;
   assign bus_oe   = oe_q;
   assign dir_n    = dir_n_q;
   assign ext_addr = addr_q;
   assign strobe_n = stb_n_q;

   // R2
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!dir_n && !strobe_n));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && $past(!strobe_n)) |-> ($stable(ext_addr) && $stable(bus_out)));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && !ready) |=> (!strobe_n && !done));

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && wait_pend) |=> !strobe_n);

   // R8
   claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == XS_IDLE && req_valid && claim_hit) |=> (strobe_n && done && $stable(rd_data)));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && req_valid) |=> $stable(ext_addr));
endmodule

// File: tb/sim_xreg_bus_if.sv
module sim_xreg_bus_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rd_data;
   logic        done;
   logic        wait_en = 1'b0;
   logic        codec_en = 1'b0;
   logic        timer_en = 1'b0;
   logic [15:0] bus_in;
   logic [15:0] bus_out;
   logic        bus_oe;
   logic        dir_n;
   logic [2:0]  ext_addr;
   logic        strobe_n;
   logic        ready = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   int n_acc = 0;
   int stall_left = 0;
   bit summary_done = 1'b0;

   logic [15:0] dev_mem [8];
   logic [15:0] shadow  [8];
   logic        cap_dir_n;
   logic [2:0]  cap_addr;
   logic [15:0] cap_data;

   always #5 clk = ~clk;

   xreg_bus_if u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
      .wait_en(wait_en), .codec_en(codec_en), .timer_en(timer_en),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dir_n(dir_n),
      .ext_addr(ext_addr), .strobe_n(strobe_n), .ready(ready)
   );

   // external register model
   assign bus_in = dev_mem[ext_addr];

   always @(negedge clk) begin
      if (strobe_n === 1'b0) begin
         cap_dir_n = dir_n;
         cap_addr  = ext_addr;
         cap_data  = bus_out;
      end
      if (strobe_n === 1'b0 && stall_left > 0) begin
         ready = 1'b0;
         stall_left = stall_left - 1;
      end else begin
         ready = 1'b1;
      end
   end

   always @(posedge strobe_n) begin
      if (cap_dir_n === 1'b0) dev_mem[cap_addr] = cap_data;
   end

   always @(negedge strobe_n) n_acc = n_acc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // one access; checks latency, held outputs, bus activity and data
   task automatic run_xfer(input string req, input bit wr, input logic [2:0] a,
                           input logic [15:0] d, input int stall, input int exp_lat,
                           input bit exp_ext, input bit poke);
      int acc0;
      int lat;
      bit hold_ok;
      logic [15:0] rd0;
      logic [15:0] mem0;
      acc0 = n_acc;
      rd0 = rd_data;
      mem0 = dev_mem[a];
      lat = 0;
      hold_ok = 1'b1;
      @(negedge clk);
      stall_left = stall;
      req_valid = 1'b1;
      req_write = wr;
      req_addr = a;
      req_wdata = d;
      while (1) begin
         @(negedge clk);
         req_valid = 1'b0;
         lat++;
         if (poke && lat == 1) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr = a ^ 3'd5;
            req_wdata = 16'hDEAD;
         end
         if (!strobe_n) begin
            if (ext_addr != a || dir_n != !wr || bus_oe != wr) hold_ok = 1'b0;
            if (wr && bus_out != d) hold_ok = 1'b0;
         end
         if (done || lat > 40) break;
      end
      check(lat == exp_lat, req, "latency", lat, exp_lat);
      check(hold_ok, "R3", "address/direction held during access", hold_ok, 1);
      check(bus_oe == 1'b0 && dir_n == 1'b1 && strobe_n == 1'b1, "R2",
            "input mode after done", {bus_oe, dir_n, strobe_n}, 3'b011);
      check((n_acc - acc0) == (exp_ext ? 1 : 0), exp_ext ? "R4" : "R8",
            "strobe falls", n_acc - acc0, exp_ext ? 1 : 0);
      if (exp_ext && wr) begin
         shadow[a] = d;
         check(dev_mem[a] == d, "R4", "device stored write", dev_mem[a], d);
      end else if (exp_ext) begin
         check(rd_data == shadow[a], "R5", "read data", rd_data, shadow[a]);
      end else begin
         check(rd_data == rd0, "R8", "rd_data unchanged", rd_data, rd0);
         check(dev_mem[a] == mem0, "R8", "register untouched", dev_mem[a], mem0);
      end
      @(negedge clk);
      check(done == 1'b0, "R5", "done single cycle", done, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(bus_oe == 1'b0 && dir_n == 1'b1, "R1", "bus input mode", {bus_oe, dir_n}, 2'b01);
      check(strobe_n == 1'b1 && done == 1'b0, "R1", "strobe idle, no done",
            {strobe_n, done}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_all_addr();
      for (int i = 0; i < 8; i++)
         run_xfer("R4", 1'b1, 3'(i), 16'h1111 * 16'(i + 1) ^ 16'h0F0F, 0, 2, 1'b1, 1'b0);
      for (int i = 7; i >= 0; i--)
         run_xfer("R4", 1'b0, 3'(i), 16'h0, 0, 2, 1'b1, 1'b0);
   endtask

   task automatic t_stall();
      run_xfer("R6", 1'b1, 3'd2, 16'hA5C3, 3, 5, 1'b1, 1'b0);
      run_xfer("R6", 1'b0, 3'd2, 16'h0, 2, 4, 1'b1, 1'b0);
   endtask

   task automatic t_wait();
      wait_en = 1'b1;
      run_xfer("R7", 1'b1, 3'd6, 16'h5A3C, 0, 3, 1'b1, 1'b0);
      run_xfer("R7", 1'b0, 3'd6, 16'h0, 1, 3, 1'b1, 1'b0);
      run_xfer("R7", 1'b0, 3'd1, 16'h0, 3, 5, 1'b1, 1'b0);
      wait_en = 1'b0;
   endtask

   task automatic t_claim();
      codec_en = 1'b1;
      run_xfer("R8", 1'b1, 3'd6, 16'hFFFF, 0, 1, 1'b0, 1'b0);
      run_xfer("R8", 1'b0, 3'd4, 16'h0, 0, 1, 1'b0, 1'b0);
      run_xfer("R8", 1'b0, 3'd3, 16'h0, 0, 2, 1'b1, 1'b0);
      codec_en = 1'b0;
      timer_en = 1'b1;
      run_xfer("R8", 1'b1, 3'd7, 16'h1234, 0, 1, 1'b0, 1'b0);
      timer_en = 1'b0;
      run_xfer("R8", 1'b0, 3'd7, 16'h0, 0, 2, 1'b1, 1'b0);
   endtask

   task automatic t_busy();
      int acc0;
      run_xfer("R9", 1'b0, 3'd2, 16'h0, 3, 5, 1'b1, 1'b1);
      acc0 = n_acc;
      repeat (4) @(negedge clk);
      check(n_acc == acc0 && strobe_n == 1'b1, "R9", "no access from busy request",
            n_acc - acc0, 0);
      check(dev_mem[7] == shadow[7], "R9", "poked register untouched", dev_mem[7], shadow[7]);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_all_addr();
      t_stall();
      t_wait();
      t_claim();
      t_busy();
      t_reset();
      finish_run();
   end
endmodule